// File: doc/BRIEF.md
# Accumulator Register-Reference Unit

This unit carries out the register-reference group of a 16-bit accumulator machine. The control sequencer presents the fetched instruction word and raises a strobe during timing step T3. The unit first checks that the word is a register-reference instruction: the opcode field must be all ones and the indirect bit must be clear. If it is, the unit works out the new accumulator (AC) and extension flag (E) from the values presented on its inputs. It registers the results, with write strobes that say which of the two registers the sequencer should load, and it raises a single-cycle pulse that sends the sequence counter back to zero.

Each supported operation is chosen by its own bit in the low field of the instruction. The operations are clearing AC, complementing AC, clearing E, rotating AC right through E, and incrementing AC. Several bits may be set in one word. They are then applied in a fixed chain, so one instruction can perform a composite operation. The unit has no memory access.

Top module: `acc_rref_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, acOut is 0, eOut is 0, and acLoad, eLoad and seqClr are all low.
- R2: The unit acts only when stepT3 is high, instr[14:12] is 3'b111 and instr[15] is 0. On any other cycle, the next cycle has acOut and eOut unchanged and acLoad, eLoad and seqClr low.
- R3: A qualifying cycle raises seqClr in the following cycle, and only in that cycle.
- R4: instr bit 11 clears AC (word 16'h7800 gives acOut = 0, with E unchanged).
- R5: instr bit 9 replaces AC with its bitwise complement (word 16'h7200).
- R6: instr bit 10 clears E and leaves AC unchanged (word 16'h7400).
- R7: instr bit 7 rotates right through E (word 16'h7080): the new AC is {E, AC[15:1]} and the new E is AC[0].
- R8: instr bit 5 increments AC modulo 2^16 and leaves E unchanged (word 16'h7020). For example, 16'hFFFF becomes 0.
- R9: When several operation bits are set, they are applied in this order: clear AC, clear E, complement AC, rotate, increment. Each step works on the result of the step before it.
- R10: A qualifying word with none of bits 11, 10, 9, 7 or 5 set gives acOut = acIn, eOut = eIn, acLoad = 0, eLoad = 0 and seqClr = 1.
- R11: On a qualifying cycle, acLoad is set when any of bits 11, 9, 7 or 5 is set. eLoad is set when bit 10 or bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepT3 | input | 1 | Sequencer is in timing step T3 |
| instr | input | 16 | Instruction word held in the instruction register |
| acIn | input | 16 | Current accumulator value |
| eIn | input | 1 | Current extension flag |
| acOut | output | 16 | New accumulator value |
| eOut | output | 1 | New extension flag |
| acLoad | output | 1 | Load acOut into the accumulator |
| eLoad | output | 1 | Load eOut into the extension flag |
| seqClr | output | 1 | Clear the sequence counter |

## Verification
Every cycle, the assertions check the qualification and timing of seqClr. They also check that the outputs hold on cycles that do not qualify, that a write strobe never appears without seqClr, and that the clear, complement, rotate and increment words each produce their result one cycle later. Only the bench's scenarios can show how combined operation bits chain in their fixed order, the wrap of the increment at all ones, and the no-op word with the pass-through values it must return.

// File: rtl/acc_rref_pkg.sv
package acc_rref_pkg;

  // Strobes passed from the decode control to the datapath.
  typedef struct packed {
    logic fire;   // qualifying register-reference cycle
    logic clrAc;
    logic clrE;
    logic cmpAc;
    logic shrAc;
    logic incAc;
  } rrStrobe_t;

endpackage

// File: rtl/acc_rref_ctrl.sv
module acc_rref_ctrl
  import acc_rref_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CLR_AC_BIT = 11,
  parameter int CLR_E_BIT  = 10,
  parameter int CMP_AC_BIT = 9,
  parameter int SHR_AC_BIT = 7,
  parameter int INC_AC_BIT = 5
) (
  input  logic              stepT3,
  input  logic [DATA_W-1:0] instr,
  output rrStrobe_t         strobes
);

  localparam int IND_BIT = DATA_W - 1;
  localparam int OPC_HI  = DATA_W - 2;
  localparam int OPC_LO  = DATA_W - 4;

  logic isRegRef;

  // The opcode field must be all ones and the indirect bit clear.
  always_comb begin
    isRegRef = stepT3 && (&instr[OPC_HI:OPC_LO]) && !instr[IND_BIT];
    strobes.fire  = isRegRef;
    strobes.clrAc = isRegRef && instr[CLR_AC_BIT];
    strobes.clrE  = isRegRef && instr[CLR_E_BIT];
    strobes.cmpAc = isRegRef && instr[CMP_AC_BIT];
    strobes.shrAc = isRegRef && instr[SHR_AC_BIT];
    strobes.incAc = isRegRef && instr[INC_AC_BIT];
  end

  // R2: no operation strobe is raised outside a qualifying T3 cycle.
  always_comb begin
    p_strobe_gate_r2: assert (strobes.fire ||
      !(strobes.clrAc || strobes.clrE || strobes.cmpAc || strobes.shrAc || strobes.incAc))
      else $error("operation strobe raised without a qualifying cycle");
  end

endmodule

// File: rtl/acc_rref_dp.sv
module acc_rref_dp
  import acc_rref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rrStrobe_t         strobes,
  input  logic [DATA_W-1:0] acIn,
  input  logic              eIn,
  output logic [DATA_W-1:0] acOut,
  output logic              eOut,
  output logic              acLoad,
  output logic              eLoad,
  output logic              seqClr
);

  logic [DATA_W-1:0] acNext;
  logic              eNext;
  logic              acWrite;
  logic              eWrite;

  // The operations are applied in a fixed chain: clear AC, clear E,
  // complement, rotate through E, then increment.
  always_comb begin
    acNext = acIn;
    eNext  = eIn;
    if (strobes.clrAc) acNext = '0;
    if (strobes.clrE)  eNext  = 1'b0;
    if (strobes.cmpAc) acNext = ~acNext;
    if (strobes.shrAc) {acNext, eNext} = {eNext, acNext};
    if (strobes.incAc) acNext = acNext + DATA_W'(1);
    acWrite = strobes.clrAc || strobes.cmpAc || strobes.shrAc || strobes.incAc;
    eWrite  = strobes.clrE || strobes.shrAc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acOut  <= '0;
      eOut   <= 1'b0;
      acLoad <= 1'b0;
      eLoad  <= 1'b0;
      seqClr <= 1'b0;
    end else if (strobes.fire) begin
      acOut  <= acNext;
      eOut   <= eNext;
      acLoad <= acWrite;
      eLoad  <= eWrite;
      seqClr <= 1'b1;
    end else begin
      acLoad <= 1'b0;
      eLoad  <= 1'b0;
      seqClr <= 1'b0;
    end
  end

  // R2: the outputs hold across cycles that do not qualify.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fire |=> ($stable(acOut) && $stable(eOut) && !seqClr))
    else $error("outputs changed on a cycle that did not qualify");

  // R11: a write strobe is never raised without the counter clear.
  p_load_with_clr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (acLoad || eLoad) |-> seqClr)
    else $error("write strobe without seqClr");

endmodule

// File: rtl/acc_rref_unit.sv
module acc_rref_unit
  import acc_rref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepT3,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] acIn,
  input  logic              eIn,
  output logic [DATA_W-1:0] acOut,
  output logic              eOut,
  output logic              acLoad,
  output logic              eLoad,
  output logic              seqClr
);

  rrStrobe_t strobes;

  acc_rref_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .stepT3 (stepT3),
    .instr  (instr),
    .strobes(strobes)
  );

  acc_rref_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .acIn   (acIn),
    .eIn    (eIn),
    .acOut  (acOut),
    .eOut   (eOut),
    .acLoad (acLoad),
    .eLoad  (eLoad),
    .seqClr (seqClr)
  );

  // R3: seqClr follows a qualifying T3 word by exactly one cycle.
  p_seqclr_timing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepT3 && instr[DATA_W-2:DATA_W-4] == 3'b111 && !instr[DATA_W-1]) |=> seqClr)
    else $error("seqClr missing after qualifying word");

  // R4: the clear-AC word yields zero with E untouched.
  p_clear_ac_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stepT3 && instr == DATA_W'(16'h7800)) |=> (acOut == '0 && eOut == $past(eIn) && acLoad && !eLoad))
    else $error("clear-AC result wrong");

  // R5: the complement word inverts AC.
  p_cmp_ac_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepT3 && instr == DATA_W'(16'h7200)) |=> (acOut == ~$past(acIn)))
    else $error("complement result wrong");

  // R7: the rotate word moves E into the top bit and bit 0 into E.
  p_rotate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stepT3 && instr == DATA_W'(16'h7080)) |=>
      (acOut == {$past(eIn), $past(acIn[DATA_W-1:1])} && eOut == $past(acIn[0])))
    else $error("rotate result wrong");

  // R8: the increment word adds one modulo 2^DATA_W.
  p_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stepT3 && instr == DATA_W'(16'h7020)) |=> (acOut == $past(acIn) + DATA_W'(1)))
    else $error("increment result wrong");

endmodule

// File: tb/acc_rref_unit_tb.sv
module acc_rref_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepT3 = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] acIn = '0;
  logic        eIn = 1'b0;
  logic [15:0] acOut;
  logic        eOut;
  logic        acLoad;
  logic        eLoad;
  logic        seqClr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  acc_rref_unit u_dut (
    .clk(clk), .rstN(rstN), .stepT3(stepT3), .instr(instr),
    .acIn(acIn), .eIn(eIn), .acOut(acOut), .eOut(eOut),
    .acLoad(acLoad), .eLoad(eLoad), .seqClr(seqClr)
  );

  // Vector: instr, acIn, eIn, expected acOut, eOut, acLoad, eLoad, seqClr.
  localparam int NV = 15;
  localparam logic [52:0] VEC [NV] = '{
    {16'h7800, 16'h1234, 1'b1, 16'h0000, 1'b1, 3'b101},  // R4
    {16'h7200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 3'b101},  // R5
    {16'h7400, 16'hABCD, 1'b1, 16'hABCD, 1'b0, 3'b011},  // R6
    {16'h7080, 16'h0003, 1'b0, 16'h0001, 1'b1, 3'b111},  // R7
    {16'h7080, 16'h8000, 1'b1, 16'hC000, 1'b0, 3'b111},  // R7
    {16'h7020, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 3'b101},  // R8 wrap
    {16'h7020, 16'h0041, 1'b0, 16'h0042, 1'b0, 3'b101},  // R8
    {16'h7001, 16'h5555, 1'b1, 16'h5555, 1'b1, 3'b001},  // R10
    {16'hF800, 16'h0F0F, 1'b0, 16'h5555, 1'b1, 3'b000},  // R2 indirect
    {16'h3800, 16'h0F0F, 1'b0, 16'h5555, 1'b1, 3'b000},  // R2 opcode
    {16'h7A00, 16'h1234, 1'b0, 16'hFFFF, 1'b0, 3'b101},  // R9
    {16'h7480, 16'h0001, 1'b1, 16'h0000, 1'b1, 3'b111},  // R9
    {16'h7220, 16'h0005, 1'b0, 16'hFFFB, 1'b0, 3'b101},  // R9
    {16'h78A0, 16'h9999, 1'b1, 16'h8001, 1'b0, 3'b111},  // R9, R11
    {16'h7020, 16'h7FFF, 1'b0, 16'h8000, 1'b0, 3'b101}   // R8, R11
  };

  function automatic string reqOf(input logic [15:0] w);
    if (w[15] || w[14:12] != 3'b111) return "R2";
    case (w)
      16'h7800: return "R4";
      16'h7200: return "R5";
      16'h7400: return "R6";
      16'h7080: return "R7";
      16'h7020: return "R8";
      16'h7001: return "R10";
      default:  return "R9/R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [20:0] got, input logic [20:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got ac=%h e=%b ld=%b%b clr=%b, expected ac=%h e=%b ld=%b%b clr=%b",
               req, got[20:5], got[4], got[3], got[2], got[1],
               exp[20:5], exp[4], exp[3], exp[2], exp[1]);
    end
  endtask

  function automatic logic [20:0] outs();
    return {acOut, eOut, acLoad, eLoad, seqClr, 1'b0};
  endfunction

  initial begin
    #1500000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    stepT3 = 1'b1; instr = 16'h7400; acIn = 16'hFFFF; eIn = 1'b1;
    @(negedge clk);
    check("R1", outs(), 21'h0);
    stepT3 = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", outs(), 21'h0);

    // Table walk, one vector per cycle.
    for (int i = 0; i < NV; i++) begin
      stepT3 = 1'b1;
      instr  = VEC[i][52:37];
      acIn   = VEC[i][36:21];
      eIn    = VEC[i][20];
      @(negedge clk);
      check(reqOf(VEC[i][52:37]), outs(), {VEC[i][19:0], 1'b0});
    end

    // R2: a valid word without the strobe changes nothing.
    stepT3 = 1'b0; instr = 16'h7800; acIn = 16'h1111; eIn = 1'b1;
    @(negedge clk);
    check("R2", outs(), {16'h8000, 1'b0, 3'b000, 1'b0});

    // R3: seqClr falls after a single pulse.
    stepT3 = 1'b1; instr = 16'h7020; acIn = 16'h0010; eIn = 1'b0;
    @(negedge clk);
    check("R3", outs(), {16'h0011, 1'b0, 3'b101, 1'b0});
    stepT3 = 1'b0;
    @(negedge clk);
    check("R3", outs(), {16'h0011, 1'b0, 3'b000, 1'b0});

    // R1: reset in mid-run clears the outputs again.
    rstN = 1'b0;
    @(negedge clk);
    check("R1", outs(), 21'h0);
    rstN = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule